// File: doc/BRIEF.md
# Encoder Bitstream Power Meter

This block estimates input signal power from the serial output of a delta-modulation encoder. It does not measure amplitude. It counts compand events instead. A compand event is a point where three consecutive accepted bits are equal, either `000` or `111`. The windows overlap, so a run of N equal bits yields N-2 events.

Events are counted over pages of a fixed number of accepted bits, 1024 by default. When a page closes, the event count is compressed into a 5-bit quasi-logarithmic code. That code is latched onto the output, and a one-cycle ready pulse tells the consumer that a fresh reading is available. The reading then holds for the whole of the next page. Status storage and interrupt generation live in the surrounding logic.

Top module: `bitstream_power_meter`

## Requirements
- R1: An event is counted when an accepted bit equals each of the two accepted bits before it (`000` or `111`). Windows overlap, so a run of N equal bits yields N-2 events.
- R2: Cycles with `bit_valid` low are ignored. They do not advance the page position or the bit history, and they cannot create an event.
- R3: A page is exactly 1024 accepted bits. `page_ready` is high for exactly one cycle, the cycle after the clock edge that accepts the page's last bit.
- R4: `power_code` changes only together with a `page_ready` pulse. It holds its value for the rest of the page.
- R5: Event counts 0 to 3 produce codes equal to the count; code `00000` means zero events.
- R6: For counts from 4 to 511, take the count's top set bit at position m. The code is 4*(m-1) plus the two bits just below that top bit. Examples: 4→4, 8→8, 10→9, 15→11, 100→22, 255→27, 256→28, 511→31.
- R7: The event count saturates at 512, and any page with 512 or more events reads `11111`.
- R8: The event count restarts at every page. The bit history carries over, so a run that crosses a page boundary scores its event in the new page.
- R9: Reset clears the page position, the event count, the bit history and the reading. After reset `power_code` is 0, `page_ready` is 0, and the first two accepted bits cannot form an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_bit | input | 1 | Encoder output bit |
| bit_valid | input | 1 | High when `enc_bit` carries a bit to accept |
| power_code | output | 5 | Quasi-log power reading of the last completed page |
| page_ready | output | 1 | One-cycle pulse when a new reading is latched |

## Verification
The bench targets the octave edges of the code map: counts 3/4, 7/8, 15/16, 255/256, 511/512, and a count past 512. A mapping error there shows up as a code one step off, and a missing clamp shows up as wrapped codes.

Two pages test the history. In one, a run crosses the page boundary, so a design that clears history per page loses that page's single event. In the other, a reset lands mid-run, so a design that keeps stale history invents one.

Invalid cycles are inserted while the bit input holds a value that would extend a run. A design that counts them reports a higher code, and one that advances the page on them closes pages early and emits an unexpected pulse.

// File: rtl/bitstream_power_meter.sv
module bitstream_power_meter #(
  parameter int PAGE_BITS = 1024,
  parameter int CODE_W    = 5,
  parameter int SAT_COUNT = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_bit,
  input  logic              bit_valid,
  output logic [CODE_W-1:0] power_code,
  output logic              page_ready
);
  localparam int PCNT_W = $clog2(PAGE_BITS);
  localparam int CCNT_W = $clog2(SAT_COUNT) + 1;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic [PCNT_W-1:0] bit_idx;
  logic [CCNT_W-1:0] evt_cnt;
  logic [1:0]        hist;
  logic [1:0]        fill;

  wire hit  = bit_valid && (fill == 2'd2) && (enc_bit == hist[0]) && (enc_bit == hist[1]);
  wire last = bit_valid && (bit_idx == PCNT_W'(PAGE_BITS - 1));
  wire [CCNT_W-1:0] cnt_next = (hit && evt_cnt != CCNT_W'(SAT_COUNT)) ? evt_cnt + 1'b1 : evt_cnt;

  function automatic logic [CODE_W-1:0] quasi_log(input logic [CCNT_W-1:0] c);
    int m;
    int code;
    m = 0;
    for (int i = 0; i < CCNT_W; i++)
      if (c[i]) m = i;
    if (c >= CCNT_W'(SAT_COUNT)) code = CODE_MAX;
    else if (m < 2)              code = int'(c);
    else                         code = 4 * (m - 1) + int'((c >> (m - 2)) & CCNT_W'(3));
    if (code > CODE_MAX) code = CODE_MAX;
    return CODE_W'(code);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx    <= '0;
      evt_cnt    <= '0;
      hist       <= '0;
      fill       <= '0;
      power_code <= '0;
      page_ready <= 1'b0;
    end else begin
      page_ready <= last;
      if (bit_valid) begin
        hist <= {hist[0], enc_bit};
        if (fill != 2'd2) fill <= fill + 1'b1;
        if (last) begin
          bit_idx    <= '0;
          evt_cnt    <= '0;
          power_code <= quasi_log(cnt_next);
        end else begin
          bit_idx <= bit_idx + 1'b1;
          evt_cnt <= cnt_next;
        end
      end
    end
  end

  assert_ready_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    page_ready |=> !page_ready);
  assert_ready_after_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    page_ready |-> $past(bit_valid));
  assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !page_ready |-> $stable(power_code));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(bit_idx) && $stable(hist) && $stable(evt_cnt)));
  assert_count_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cnt <= CCNT_W'(SAT_COUNT));
endmodule

// File: tb/bitstream_power_meter_tb.sv
module bitstream_power_meter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_bit = 1'b0;
  logic bit_valid = 1'b0;
  logic [4:0] power_code;
  logic page_ready;

  always #10 clk = ~clk;

  bitstream_power_meter dut_i (
    .clk(clk), .rst_n(rst_n), .enc_bit(enc_bit), .bit_valid(bit_valid),
    .power_code(power_code), .page_ready(page_ready)
  );

  typedef struct { int code; string tag; } exp_t;
  exp_t q[$];
  int n_checks = 0;
  int n_fail = 0;

  int m_fill = 0, m_idx = 0, m_cnt = 0;
  bit m_h0 = 0, m_h1 = 0;
  bit last_bit = 0;
  string cur_tag = "R5";

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  function automatic int exp_code(int c);
    int t, m;
    if (c >= 512) return 31;
    if (c < 4) return c;
    t = c; m = 0;
    while (t >= 8) begin t = t >> 1; m++; end
    return 4 * m + t;
  endfunction

  task automatic send(bit b);
    exp_t e;
    @(negedge clk);
    enc_bit = b; bit_valid = 1'b1;
    if (m_fill == 2 && b == m_h0 && b == m_h1) m_cnt++;
    m_h1 = m_h0; m_h0 = b;
    if (m_fill < 2) m_fill++;
    last_bit = b;
    m_idx++;
    if (m_idx == 1024) begin
      e.code = exp_code(m_cnt > 512 ? 512 : m_cnt);
      e.tag = cur_tag;
      q.push_back(e);
      m_idx = 0; m_cnt = 0;
    end
  endtask

  task automatic idle(int n, bit b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enc_bit = b; bit_valid = 1'b0;
    end
  endtask

  // one run of k+2 equal bits, opposite to the previous bit, then alternating
  task automatic page_with(int k, string tag, bit gaps);
    bit b, v;
    cur_tag = tag;
    b = ~last_bit;
    for (int i = 0; i < 1024; i++) begin
      v = (i < k + 2) ? b : (b ^ bit'((i - (k + 1)) & 1));
      if (gaps && (i % 37) == 5) idle(3, v);
      send(v);
    end
  endtask

  task automatic page_random(int rep_pct, string tag);
    bit v;
    cur_tag = tag;
    v = last_bit;
    for (int i = 0; i < 1024; i++) begin
      if (($urandom % 100) >= rep_pct) v = ~v;
      if (($urandom % 11) == 0) idle(1, v);
      send(v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_valid = 1'b0;
    m_fill = 0; m_idx = 0; m_cnt = 0; last_bit = 0;
    q.delete();
    repeat (3) @(negedge clk);
    check(power_code == 5'd0, "R9 code after reset", power_code, 0);
    check(page_ready == 1'b0, "R9 ready after reset", page_ready, 0);
    rst_n = 1'b1;
  endtask

  logic [4:0] last_code = '0;
  bit stab_bad = 0;
  bit prev_ready = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      last_code = '0; stab_bad = 0; prev_ready = 0;
    end else begin
      if (page_ready) begin
        check(!prev_ready, "R3 pulse longer than one cycle", 1, 0);
        if (q.size() == 0) begin
          check(1'b0, "R3 unexpected page_ready", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(power_code == e.code, e.tag, power_code, e.code);
        end
        check(!stab_bad, "R4 code changed mid-page", 1, 0);
        stab_bad = 0;
        last_code = power_code;
      end else if (power_code != last_code) begin
        stab_bad = 1;
      end
      prev_ready = page_ready;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    do_reset();
    cur_tag = "R7 all-equal page";
    for (int i = 0; i < 1024; i++) send(1'b0);
    cur_tag = "R8 run across boundary";
    for (int i = 0; i < 1024; i++) send(bit'(i & 1));
    page_with(0,   "R5 count 0", 0);
    page_with(2,   "R5 count 2", 0);
    page_with(3,   "R5 count 3", 0);
    page_with(4,   "R6 count 4", 0);
    page_with(5,   "R6 count 5", 0);
    page_with(7,   "R6 count 7", 0);
    page_with(8,   "R6 count 8", 0);
    page_with(10,  "R6 count 10", 0);
    page_with(15,  "R6 count 15", 0);
    page_with(16,  "R6 count 16", 0);
    page_with(100, "R1 count 100", 0);
    page_with(255, "R6 count 255", 0);
    page_with(256, "R6 count 256", 0);
    page_with(511, "R6 count 511", 0);
    page_with(512, "R7 count 512", 0);
    page_with(700, "R7 count 700", 0);
    page_with(6,   "R2 gaps count 6", 1);
    page_with(60,  "R2 gaps count 60", 1);
    page_random(50, "R1 random 50");
    page_random(75, "R1 random 75");
    page_random(90, "R1 random 90");
    page_with(512, "R7 before reset", 0);
    for (int i = 0; i < 500; i++) send(1'b0);
    do_reset();
    cur_tag = "R9 history cleared";
    for (int i = 0; i < 1024; i++) send(bit'(i & 1));
    page_with(3, "R9 fresh page", 0);
    @(negedge clk);
    bit_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(q.size() == 0, "R3 missing page_ready", q.size(), 0);
    finish_run();
  end
endmodule